// File: doc/BRIEF.md
# Dual-Rate External Bus Clock Divider

This block derives the clock, or the pacing strobe, of a parallel external bus from the system clock. A 32-bit control word holds two 16-bit count fields. The divide ratio is not the count itself. The lowest bit of the count is dropped, so a nonzero count `c` divides the system clock by `2*(floor(c/2)+1)`. A count of zero gives no division at all: the output follows the system clock, and the strobe stays high.

The lower count field serves every access by default. When the chip-select configuration input selects one of the two dual chip-select settings (value 2 or 3) and the per-region rate enable is set, the upper field paces accesses in the second chip-select region. The lower field then paces accesses in the first region. Address decoding happens outside the block, which only receives a region indicator.

A new count or a new region takes effect only at the end of a full output period, so the bus never sees a shortened pulse. Along with the divided clock, the block gives a strobe that is high for one system-clock cycle at each rising edge of the divided clock.

Top module: `extbus_clkdiv`

## Requirements
- R1: While `rst` is high (synchronous, active high), the control word reads 0, `bus_clk` is low and `bus_stb` is low.
- R2: When the selected count is 0, `bus_stb` is high in every cycle and `bus_clk` follows the system clock.
- R3: For a nonzero selected count `c` with `h = floor(c/2)+1`, `bus_clk` is high for `h` system cycles and then low for `h` cycles, repeating with a period of `2*h`.
- R4: A count of 1 gives a period of 2 system cycles, and counts of 2 and 3 both give a period of 4.
- R5: For a nonzero count, `bus_stb` is high for exactly one cycle per period: the first cycle in which `bus_clk` is high.
- R6: A write (`wr_en` high) always stores `wr_data[15:0]` as the primary count. `rd_data[15:0]` returns that count from the cycle after the write.
- R7: `wr_data[31:16]` is stored as the secondary count only when dual-rate operation is active at the time of the write. Dual-rate operation is active when `cs_cfg` is 2 or 3 and `rate_split` is 1. At any other time, the upper half of the word is left unchanged.
- R8: The secondary count is used only when dual-rate operation is active and `cs_region` is 1. In every other case, including `cs_cfg` equal to 1 with `rate_split` set, the primary count is used.
- R9: A change of the selected count, whether from a write or from `cs_region`, takes effect only when the current output period is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Write data: primary count in 15:0, secondary count in 31:16 |
| rd_data | output | 32 | Current control word |
| cs_cfg | input | 2 | Chip-select configuration; 2 or 3 means dual chip selects |
| rate_split | input | 1 | Per-region rate enable |
| cs_region | input | 1 | Region of the current access: 0 first, 1 second |
| bus_clk | output | 1 | Divided external bus clock |
| bus_stb | output | 1 | One-cycle enable at each rising edge of `bus_clk` |

## Verification
The assertions check on every cycle the following local rules:
- Every rising edge of the divided clock carries the strobe.
- A strobe in divide mode lasts a single cycle.
- The strobe stays high in pass-through mode.
- The latched ratio holds still inside a period.
- A write outside dual-rate mode leaves the upper count alone.

The high and low run lengths for each count, the choice between the two fields for each configuration and region, and an old period running to its end after a region change can be shown only by the bench's scenarios. The bench shows these by sampling the outputs across whole periods.

// File: rtl/extbus_clkdiv_pkg.sv
package extbus_clkdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_DIV  = 2'd2
    } div_state_e;

endpackage

// File: rtl/extbus_ctrl_reg.sv
module extbus_ctrl_reg #(
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [2*CW-1:0] wr_data,
    input  logic            dual_on,
    output logic [2*CW-1:0] ctrl_q
);
    logic [2*CW-1:0] ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d[CW-1:0] = wr_data[CW-1:0];
            if (dual_on) begin
                ctrl_d[2*CW-1:CW] = wr_data[2*CW-1:CW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    // R7: upper count untouched by writes outside dual-rate mode
    p_sec_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !dual_on) |=> $stable(ctrl_q[2*CW-1:CW]));

endmodule

// File: rtl/extbus_rate_sel.sv
module extbus_rate_sel #(
    parameter int CW = 16
) (
    input  logic [2*CW-1:0] ctrl,
    input  logic [1:0]      cs_cfg,
    input  logic            rate_split,
    input  logic            cs_region,
    output logic            dual_on,
    output logic [CW-1:0]   sel_count
);
    localparam logic [1:0] CFG_DUAL_A = 2'd2;
    localparam logic [1:0] CFG_DUAL_B = 2'd3;

    always_comb begin
        dual_on = rate_split && ((cs_cfg == CFG_DUAL_A) || (cs_cfg == CFG_DUAL_B));
        if (dual_on && cs_region) sel_count = ctrl[2*CW-1:CW];
        else                      sel_count = ctrl[CW-1:0];
    end

endmodule

// File: rtl/extbus_div_core.sv
module extbus_div_core
    import extbus_clkdiv_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] sel_count,
    output logic          bus_clk,
    output logic          bus_stb
);
    localparam logic [CW-1:0] ONE_C = 1;
    localparam logic [CW:0]   ONE_W = 1;

    typedef struct packed {
        div_state_e    st;
        logic          clk;
        logic          stb;
        logic [CW-1:0] half;
        logic [CW-1:0] cnt;
    } core_t;

    core_t       core_d, core_q;
    logic        load;
    logic [CW:0] last_w;
    logic [CW:0] fall_w;

    always_comb begin
        core_d     = core_q;
        core_d.stb = 1'b0;
        load       = 1'b0;
        last_w     = {core_q.half, 1'b0} - ONE_W;
        fall_w     = {1'b0, core_q.half} - ONE_W;
        case (core_q.st)
            ST_DIV: begin
                core_d.cnt = core_q.cnt + ONE_C;
                if ({1'b0, core_q.cnt} == fall_w) core_d.clk = 1'b0;
                if ({1'b0, core_q.cnt} == last_w) load = 1'b1;
            end
            default: load = 1'b1;
        endcase
        if (load) begin
            core_d.cnt = '0;
            core_d.stb = 1'b1;
            if (sel_count == '0) begin
                core_d.st   = ST_PASS;
                core_d.clk  = 1'b0;
                core_d.half = '0;
            end else begin
                core_d.st   = ST_DIV;
                core_d.clk  = 1'b1;
                core_d.half = (sel_count >> 1) + ONE_C;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q.st   <= ST_IDLE;
            core_q.clk  <= 1'b0;
            core_q.stb  <= 1'b0;
            core_q.half <= '0;
            core_q.cnt  <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign bus_clk = (core_q.st == ST_PASS) ? clk : core_q.clk;
    assign bus_stb = core_q.stb;

    // R5: every rising edge of the divided clock comes with the strobe
    p_stb_at_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(core_q.clk) |-> core_q.stb);

    // R5: strobe lasts one cycle in divide mode
    p_single_stb_r5: assert property (@(posedge clk) disable iff (rst)
        (core_q.st == ST_DIV && core_q.stb) |=> !core_q.stb);

    // R2: pass-through keeps the strobe high
    p_pass_stb_r2: assert property (@(posedge clk) disable iff (rst)
        (core_q.st == ST_PASS) |-> core_q.stb);

    // R9: latched ratio fixed inside a period
    p_hold_ratio_r9: assert property (@(posedge clk) disable iff (rst)
        (core_q.st == ST_DIV && core_q.cnt != '0) |-> $stable(core_q.half));

endmodule

// File: rtl/extbus_clkdiv.sv
module extbus_clkdiv #(
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [2*CW-1:0] wr_data,
    output logic [2*CW-1:0] rd_data,
    input  logic [1:0]      cs_cfg,
    input  logic            rate_split,
    input  logic            cs_region,
    output logic            bus_clk,
    output logic            bus_stb
);
    logic            dual_on;
    logic [2*CW-1:0] ctrl_q;
    logic [CW-1:0]   sel_count;

    extbus_ctrl_reg #(.CW(CW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .dual_on (dual_on),
        .ctrl_q  (ctrl_q)
    );

    extbus_rate_sel #(.CW(CW)) u_sel (
        .ctrl       (ctrl_q),
        .cs_cfg     (cs_cfg),
        .rate_split (rate_split),
        .cs_region  (cs_region),
        .dual_on    (dual_on),
        .sel_count  (sel_count)
    );

    extbus_div_core #(.CW(CW)) u_core (
        .clk       (clk),
        .rst       (rst),
        .sel_count (sel_count),
        .bus_clk   (bus_clk),
        .bus_stb   (bus_stb)
    );

    assign rd_data = ctrl_q;

endmodule

// File: tb/sim_extbus_clkdiv.sv
`timescale 1ns/100ps
module sim_extbus_clkdiv;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [1:0]  cs_cfg = 2'd0;
    logic        rate_split = 1'b0;
    logic        cs_region = 1'b0;
    logic        bus_clk, bus_stb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    localparam int NV = 7;
    localparam logic [15:0] VEC_CNT  [NV] = '{16'd0, 16'd1, 16'd2, 16'd3, 16'd4, 16'd7, 16'd10};
    localparam int          VEC_HALF [NV] = '{0, 1, 2, 2, 3, 4, 6};

    always #2.5 clk = ~clk;

    extbus_clkdiv u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .cs_cfg(cs_cfg), .rate_split(rate_split), .cs_region(cs_region),
        .bus_clk(bus_clk), .bus_stb(bus_stb)
    );

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    task automatic find_stb(output bit found);
        found = 0;
        for (int k = 0; k < 64 && !found; k++) begin
            @(negedge clk);
            if (bus_stb) found = 1;
        end
    endtask

    // Samples one full period from the strobe, plus the next rising edge
    task automatic measure(int h, string req);
        bit found;
        int bad_i;
        logic got_c, got_s, exp_c, exp_s;
        bad_i = -1;
        got_c = 0; got_s = 0; exp_c = 0; exp_s = 0;
        find_stb(found);
        if (!found) begin
            check(0, req, "no strobe seen", 0, 1);
            return;
        end
        for (int i = 0; i <= 2*h; i++) begin
            if (i > 0) @(negedge clk);
            if (bad_i < 0) begin
                exp_c = (i < h) || (i == 2*h);
                exp_s = (i == 0) || (i == 2*h);
                if (bus_clk !== exp_c || bus_stb !== exp_s) begin
                    bad_i = i; got_c = bus_clk; got_s = bus_stb;
                end
            end
        end
        check(bad_i < 0, req, $sformatf("waveform half=%0d bad sample %0d {clk,stb}", h, bad_i),
              {got_c, got_s}, {exp_c, exp_s});
    endtask

    task automatic check_pass(string req);
        bit ok;
        ok = 1;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1;
            if (bus_clk !== 1'b1 || bus_stb !== 1'b1) ok = 0;
            @(negedge clk); #0.5;
            if (bus_clk !== 1'b0 || bus_stb !== 1'b1) ok = 0;
        end
        check(ok, req, "pass-through clock with steady strobe", ok, 1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        bit found;
        int bad;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(rd_data == 32'h0, "R1", "rd_data in reset", rd_data, 0);
        check(bus_clk == 1'b0, "R1", "bus_clk in reset", bus_clk, 0);
        check(bus_stb == 1'b0, "R1", "bus_stb in reset", bus_stb, 0);
        rst = 1'b0;

        // Vector walk: primary count only
        for (int i = 0; i < NV; i++) begin
            wr({16'hABCD, VEC_CNT[i]});
            check(rd_data == {16'h0, VEC_CNT[i]}, "R6", "readback primary", rd_data, {16'h0, VEC_CNT[i]});
            settle();
            if (VEC_HALF[i] == 0) check_pass("R2");
            else measure(VEC_HALF[i], (VEC_CNT[i] >= 1 && VEC_CNT[i] <= 3) ? "R4" : "R3");
        end

        // R7: secondary stored in dual-rate mode
        cs_cfg = 2'd2; rate_split = 1'b1; cs_region = 1'b0;
        wr(32'h0001_0006);
        check(rd_data == 32'h0001_0006, "R7", "dual write readback", rd_data, 32'h0001_0006);
        settle();
        measure(4, "R8");
        cs_region = 1'b1; settle();
        measure(1, "R8");
        cs_cfg = 2'd1; settle();
        measure(4, "R8");
        cs_cfg = 2'd3; rate_split = 1'b0; settle();
        measure(4, "R8");

        // R7: upper field ignored outside dual-rate mode
        cs_cfg = 2'd0;
        wr(32'h0005_0003);
        check(rd_data == 32'h0001_0003, "R7", "upper field ignored", rd_data, 32'h0001_0003);

        // R9: region flip mid-period keeps the current period whole
        cs_cfg = 2'd3; rate_split = 1'b1; cs_region = 1'b0;
        wr(32'h0001_0006);
        settle();
        find_stb(found);
        bad = -1;
        for (int i = 0; i <= 10; i++) begin
            logic ec, es;
            if (i > 0) @(negedge clk);
            if (i == 2) cs_region = 1'b1;
            ec = (i < 4) || (i == 8) || (i == 10);
            es = (i == 0) || (i == 8) || (i == 10);
            if (bad < 0 && (bus_clk !== ec || bus_stb !== es)) bad = i;
        end
        check(found && bad < 0, "R9", "region change waits for period end (bad sample)", bad, -1);

        // R9: count write mid-period
        cs_region = 1'b0; settle();
        find_stb(found);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h0001_0002;
        @(negedge clk);
        wr_en = 1'b0;
        bad = -1;
        for (int i = 2; i <= 10; i++) begin
            logic ec, es;
            if (i > 2) @(negedge clk);
            ec = (i < 4) || (i == 8) || (i == 9);
            es = (i == 8);
            if (bad < 0 && (bus_clk !== ec || bus_stb !== es)) bad = i;
        end
        check(found && bad < 0, "R9", "count change waits for period end (bad sample)", bad, -1);

        // R1: reset again mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check(rd_data == 32'h0 && bus_clk == 1'b0 && bus_stb == 1'b0, "R1", "reset mid-run",
              {rd_data, bus_clk, bus_stb}, 0);
        rst = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule